// File: doc/BRIEF.md
# Processor Trap Entry Dispatcher

This block sits at the back of a processor pipeline and turns fault requests into trap entries. Each cycle the pipeline presents a bit mask of fault requests together with the program counter of the instruction that raised them. When more than one bit is set, a fixed priority picks one class. The block then computes a redirect address from a software-writable privileged base register plus a fixed per-class vector offset. Bit 0 of every offset is set, so the redirect address tells the fetch unit to run in privileged mode. The block presents that address with a one-cycle valid strobe.

During the same entry the block decides whether the faulting PC goes into the exception-address register. The PC is stored when the class always records its restart point, or when the PC is word aligned. Classes that behave as traps move the stored address forward by one 4-byte instruction. The effect is that the handler returns past the instruction that raised the trap.

Every class has its own occurrence counter, and a select input reads the counters one at a time. An arithmetic trap request is recognised but never serviced. It raises an error pulse in place of a redirect.

Top module: `trap_dispatch`

## Requirements
- R1: After reset, redirect_valid, arith_err and exc_addr are 0, every counter reads 0, and the base register is 0, so a reset fault redirects to 0x0000_0001.
- R2: fault_req bit positions and vector offsets are: bit0 reset 0x0001, bit1 machine check 0x0401, bit2 arithmetic (not serviced), bit3 instruction access violation 0x0081, bit4 instruction TLB miss 0x0181, bit5 double data-TLB miss 0x0281, bit6 single data-TLB miss 0x0201, bit7 data page fault 0x0381, bit8 data access violation 0x0381, bit9 unaligned access 0x0301, bit10 illegal opcode 0x0481, bit11 float disabled 0x0581, bit12 integer overflow 0x0501, bit13 privileged call 0x2001, bit14 interrupt 0x0101.
- R3: A request sampled at a clock edge drives redirect_valid high for exactly the following cycle. In that cycle redirect_pc equals the base register value at the sampling edge plus the vector offset of the chosen class. With no request, redirect_valid is 0 in the next cycle.
- R4: When several bits are set, the lowest set bit index wins.
- R5: On entry, exc_addr takes cur_pc when the class is not interrupt (bit14) or privileged call (bit13), or when cur_pc[1:0] is 0. Otherwise exc_addr keeps its value.
- R6: For integer overflow (bit12) and privileged call (bit13), the exc_addr value after step R5 is increased by 4. This includes the case where no PC was stored.
- R7: The counter of the chosen class increments by one on each entry, and cnt_value shows counter cnt_sel combinationally. Select values above 14 read 0.
- R8: If arithmetic (bit2) wins, arith_err pulses for one cycle. redirect_valid stays 0, and exc_addr and all counters are unchanged.
- R9: base_we loads base_wdata at the clock edge. An entry sampled at that same edge still uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_req | input | 15 | Fault request mask, one bit per class |
| cur_pc | input | AW | PC of the faulting instruction |
| base_we | input | 1 | Write strobe for the privileged base register |
| base_wdata | input | AW | New base register value |
| cnt_sel | input | 4 | Counter readout select |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | AW | Redirect target |
| exc_addr | output | AW | Exception (restart) address register |
| arith_err | output | 1 | Unserviced arithmetic trap pulse |
| cnt_value | output | CW | Selected occurrence counter |

## Verification
A wrong priority choice shows up one cycle after the request as a wrong redirect_pc offset and a count on the wrong counter. A fault in the restart-save or trap-advance logic shows up in exc_addr in that same cycle. An advance applied to a stale value stays wrong in every later entry that does not store a new PC. A corrupted base register or counter is visible from the next entry or readout onward. The bench therefore sweeps every class against all four PC alignments and every pair of classes, and reads back every counter.

// File: rtl/tde_pkg.sv
package tde_pkg;
  localparam int NCLS  = 15;
  localparam int CLS_W = 4;
  localparam int VOFF_W = 16;

  typedef enum logic [CLS_W-1:0] {
    C_RESET    = 4'd0,
    C_MCHK     = 4'd1,
    C_ARITH    = 4'd2,
    C_IACV     = 4'd3,
    C_IMISS    = 4'd4,
    C_DMISS2   = 4'd5,
    C_DMISS1   = 4'd6,
    C_DPAGE    = 4'd7,
    C_DACV     = 4'd8,
    C_UNALIGN  = 4'd9,
    C_OPDEC    = 4'd10,
    C_FPOFF    = 4'd11,
    C_INTOVF   = 4'd12,
    C_PRIVCALL = 4'd13,
    C_INTR     = 4'd14
  } fcls_e;

  // Per-class entry offset; bit 0 marks privileged mode.
  function automatic logic [VOFF_W-1:0] vec_off(input logic [CLS_W-1:0] c);
    case (fcls_e'(c))
      C_RESET:    return 16'h0001;
      C_MCHK:     return 16'h0401;
      C_ARITH:    return 16'h0501;
      C_IACV:     return 16'h0081;
      C_IMISS:    return 16'h0181;
      C_DMISS2:   return 16'h0281;
      C_DMISS1:   return 16'h0201;
      C_DPAGE:    return 16'h0381;
      C_DACV:     return 16'h0381;
      C_UNALIGN:  return 16'h0301;
      C_OPDEC:    return 16'h0481;
      C_FPOFF:    return 16'h0581;
      C_INTOVF:   return 16'h0501;
      C_PRIVCALL: return 16'h2001;
      C_INTR:     return 16'h0101;
      default:    return 16'h0000;
    endcase
  endfunction

  // Class always records its restart PC regardless of alignment.
  function automatic logic forces_save(input logic [CLS_W-1:0] c);
    return !((fcls_e'(c) == C_INTR) || (fcls_e'(c) == C_PRIVCALL));
  endfunction

  // Class resumes after the faulting instruction.
  function automatic logic is_trap(input logic [CLS_W-1:0] c);
    return (fcls_e'(c) == C_INTOVF) || (fcls_e'(c) == C_PRIVCALL);
  endfunction
endpackage

// File: rtl/tde_prio.sv
module tde_prio #(
  parameter int N  = 15,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  win_oh,
  output logic [IW-1:0] win_idx,
  output logic          any
);
  logic [N:0] below;

  assign below[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign below[g+1] = below[g] | req[g];
    assign win_oh[g]  = req[g] & ~below[g];
  end
  assign any = below[N];

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N; i++)
      if (win_oh[i]) win_idx = IW'(i);
  end

  p_single_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && (any == (win_oh != '0)));
endmodule

// File: rtl/tde_epc.sv
module tde_epc #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          save_force,
  input  logic          trap,
  input  logic [AW-1:0] cur_pc,
  output logic [AW-1:0] exc_addr
);
  logic [AW-1:0] exc_q;
  logic          do_save;

  function automatic logic [AW-1:0] next_exc(
      input logic [AW-1:0] old_v, input logic [AW-1:0] pc,
      input logic sv, input logic tr);
    logic [AW-1:0] b;
    b = sv ? pc : old_v;
    return tr ? b + AW'(4) : b;
  endfunction

  assign do_save = save_force || (cur_pc[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n)    exc_q <= '0;
    else if (take) exc_q <= next_exc(exc_q, cur_pc, do_save, trap);
  end
  assign exc_addr = exc_q;

  p_hold_unsaved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !do_save && !trap) |=> $stable(exc_q));
  p_adv_unsaved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !do_save && trap) |=> (exc_q == $past(exc_q) + AW'(4)));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(exc_q));
endmodule

// File: rtl/tde_ctr_bank.sv
module tde_ctr_bank #(
  parameter int N  = 15,
  parameter int CW = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  inc,
  input  logic [SW-1:0] sel,
  output logic [CW-1:0] value
);
  logic [CW-1:0] cnt_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q[g] <= '0;
      else if (inc[g]) cnt_q[g] <= cnt_q[g] + CW'(1);
    end

    p_ctr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inc[g] |=> (cnt_q[g] == $past(cnt_q[g]) + CW'(1)));
    p_ctr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !inc[g] |=> $stable(cnt_q[g]));
  end

  always_comb begin
    value = '0;
    for (int i = 0; i < N; i++)
      if (sel == SW'(i)) value = cnt_q[i];
  end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [tde_pkg::NCLS-1:0]  fault_req,
  input  logic [AW-1:0]             cur_pc,
  input  logic                      base_we,
  input  logic [AW-1:0]             base_wdata,
  input  logic [tde_pkg::CLS_W-1:0] cnt_sel,
  output logic                      redirect_valid,
  output logic [AW-1:0]             redirect_pc,
  output logic [AW-1:0]             exc_addr,
  output logic                      arith_err,
  output logic [CW-1:0]             cnt_value
);
  import tde_pkg::*;

  logic [NCLS-1:0]  win_oh;
  logic [CLS_W-1:0] win_idx;
  logic             any_req;
  logic             arith_win;
  logic             take;
  logic [NCLS-1:0]  ctr_inc;
  logic [AW-1:0]    base_q;
  logic [AW-1:0]    rpc_q;
  logic             rvalid_q;
  logic             aerr_q;

  tde_prio #(.N(NCLS)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (fault_req),
    .win_oh  (win_oh),
    .win_idx (win_idx),
    .any     (any_req)
  );

  assign arith_win = win_oh[C_ARITH];
  assign take      = any_req && !arith_win;
  assign ctr_inc   = take ? win_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      rpc_q    <= '0;
      rvalid_q <= 1'b0;
      aerr_q   <= 1'b0;
    end else begin
      if (base_we) base_q <= base_wdata;
      rvalid_q <= take;
      aerr_q   <= any_req && arith_win;
      if (take) rpc_q <= base_q + AW'(vec_off(win_idx));
    end
  end

  tde_epc #(.AW(AW)) u_epc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .save_force (forces_save(win_idx)),
    .trap       (is_trap(win_idx)),
    .cur_pc     (cur_pc),
    .exc_addr   (exc_addr)
  );

  tde_ctr_bank #(.N(NCLS), .CW(CW), .SW(CLS_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ctr_inc),
    .sel   (cnt_sel),
    .value (cnt_value)
  );

  assign redirect_valid = rvalid_q;
  assign redirect_pc    = rpc_q;
  assign arith_err      = aerr_q;

  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rvalid_q);
  p_valid_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !rvalid_q);
  p_arith_no_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(aerr_q && rvalid_q));
  p_base_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !base_we |=> $stable(base_q));
  p_priv_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && base_q[0] == 1'b0) |=> rpc_q[0]);
endmodule

// File: tb/sim_trap_dispatch.sv
module sim_trap_dispatch;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int NC = 15;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] fault_req = '0;
  logic [AW-1:0] cur_pc = '0, base_wdata = '0;
  logic base_we = 1'b0;
  logic [3:0] cnt_sel = '0;
  logic redirect_valid, arith_err;
  logic [AW-1:0] redirect_pc, exc_addr;
  logic [CW-1:0] cnt_value;

  int checks = 0, fails = 0;
  logic [AW-1:0] m_base = '0, m_exc = '0;
  int m_cnt [NC];

  always #(TCLK/2) clk = ~clk;

  trap_dispatch #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .cur_pc(cur_pc),
    .base_we(base_we), .base_wdata(base_wdata), .cnt_sel(cnt_sel),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .exc_addr(exc_addr), .arith_err(arith_err), .cnt_value(cnt_value));

  function automatic logic [AW-1:0] exp_off(int c);
    case (c)
      0: return 32'h1;    1: return 32'h401;  3: return 32'h81;
      4: return 32'h181;  5: return 32'h281;  6: return 32'h201;
      7, 8: return 32'h381; 9: return 32'h301; 10: return 32'h481;
      11: return 32'h581; 12: return 32'h501; 13: return 32'h2001;
      14: return 32'h101; default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_ctr(input int c, input int exp, input string tag);
    @(negedge clk);
    cnt_sel = 4'(c);
    #1;
    chk(cnt_value == CW'(exp), tag, AW'(cnt_value), AW'(exp));
  endtask

  // One request cycle; checks the outputs of the cycle that follows.
  task automatic apply(input logic [NC-1:0] req, input logic [AW-1:0] pc,
                       input bit we, input logic [AW-1:0] wd);
    int w;
    logic [AW-1:0] b;
    @(negedge clk);
    fault_req = req; cur_pc = pc; base_we = we; base_wdata = wd;
    @(negedge clk);
    fault_req = '0; base_we = 1'b0;
    w = -1;
    for (int i = NC - 1; i >= 0; i--) if (req[i]) w = i;
    if (w == 2) begin
      chk(arith_err == 1'b1, "R8 arith_err", AW'(arith_err), 1);
      chk(redirect_valid == 1'b0, "R8 no redirect", AW'(redirect_valid), 0);
      chk(exc_addr == m_exc, "R8 exc unchanged", exc_addr, m_exc);
    end else if (w >= 0) begin
      chk(redirect_valid == 1'b1, "R3 valid", AW'(redirect_valid), 1);
      chk(redirect_pc == m_base + exp_off(w), "R2 R4 R9 redirect_pc",
          redirect_pc, m_base + exp_off(w));
      b = ((w != 13 && w != 14) || pc[1:0] == 2'b00) ? pc : m_exc;
      if (w == 12 || w == 13) b = b + 4;
      m_exc = b;
      chk(exc_addr == m_exc, "R5 R6 exc_addr", exc_addr, m_exc);
      m_cnt[w]++;
    end
    if (we) m_base = wd;
    @(negedge clk);
    chk(redirect_valid == 1'b0 && arith_err == 1'b0, "R3 pulse ends",
        AW'({redirect_valid, arith_err}), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NC; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(redirect_valid == 0 && arith_err == 0, "R1 outputs idle",
        AW'({redirect_valid, arith_err}), 0);
    chk(exc_addr == '0, "R1 exc_addr", exc_addr, 0);
    for (int c = 0; c < 16; c++) read_ctr(c, 0, "R1 counter zero");
    apply(15'h0001, 32'h0, 1'b0, '0);           // R1 base zero: redirect 0x1
    apply('0, 32'h55, 1'b0, '0);                // R3 idle, nothing happens
    chk(redirect_valid == 0, "R3 no request", AW'(redirect_valid), 0);

    apply('0, '0, 1'b1, 32'h4000_0000);         // R9 load base
    for (int c = 0; c < NC; c++)
      for (int lo = 0; lo < 4; lo++)
        apply(15'(1 << c), 32'h1000_0000 + 32'(c * 256) + 32'(lo), 1'b0, '0);

    // R9: write collides with an entry; old base used, new base after.
    apply(15'h0002, 32'h2000_0010, 1'b1, 32'h8000_0000);
    apply(15'h4000, 32'h2000_0020, 1'b0, '0);

    // R4 pair sweep with mixed alignment.
    for (int a = 0; a < NC; a++)
      for (int b = 0; b < NC; b++)
        apply(15'((1 << a) | (1 << b)),
              32'h3000_0000 + 32'(a * 64 + b * 4) + 32'((a + b) % 4), 1'b0, '0);

    // R6: back-to-back privileged calls from misaligned PCs advance exc.
    apply(15'h2000, 32'h0000_0402, 1'b0, '0);
    apply(15'h2000, 32'h0000_0403, 1'b0, '0);

    for (int c = 0; c < NC; c++) read_ctr(c, m_cnt[c], "R7 counter value");
    read_ctr(15, 0, "R7 out-of-range select");
    chk(m_cnt[2] == 0, "R8 arith count model", AW'(m_cnt[2]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule